// File: doc/BRIEF.md
# Strobe-Busy Bus Master Interface

This block sits between a processor core and a simple memory bus that uses single-cycle request pulses with busy backpressure. The core hands it a load or store as a one-cycle request carrying an address, write data and per-byte enables. The unit registers the request and drives the address and write data onto the bus. In the next cycle it raises either a one-cycle read strobe or a one-cycle nonzero write byte mask.

From the cycle after that pulse, the unit watches the busy line that matches the transfer. While busy is high, it holds the bus address and write data steady. In the first cycle that busy is low, the transfer completes: a read latches the bus read data. One cycle later, a done pulse tells the core that the transfer has finished and that any read data is valid. A slave that never stalls may tie both busy lines low, which gives a fixed latency of three cycles from request to done. No slave may raise busy in the same cycle as the strobe.

Top module: `sbus_master`

## Requirements
- R1: A load request accepted in cycle c drives `bus_rstrb` high for exactly cycle c+1, with `bus_addr` equal to the request address in that cycle.
- R2: A store request accepted in cycle c drives `bus_wmask` to the request byte enables for exactly cycle c+1 and to zero otherwise. Byte-enable bit i qualifies `bus_wdata[8i+7:8i]`.
- R3: From the cycle after the pulse, the matching busy line is sampled each cycle. If it is high for b consecutive cycles, `core_done` rises in cycle c+3+b. Busy lines that stay tied low therefore give done in cycle c+3.
- R4: A read returns, on `core_rdata` while `core_done` is high, the `bus_rdata` value of the first cycle after the strobe in which `bus_rbusy` is low.
- R5: `bus_addr` and `bus_wdata` stay unchanged from the pulse cycle until the done cycle.
- R6: Read strobe and write mask are never active together. No new pulse is issued while a transfer is outstanding, and requests made while `core_idle` is low are ignored.
- R7: A store request with all byte enables zero is ignored: no pulse, no done, and memory is left unchanged.
- R8: If load and store are requested in the same cycle, only the load is performed.
- R9: After reset, `core_idle` is 1, and `core_done`, `bus_rstrb` and `bus_wmask` are 0.
- R10: `core_done` is high for a single cycle per transfer, and `core_idle` is high again in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_load | input | 1 | One-cycle load request |
| req_store | input | 1 | One-cycle store request |
| req_addr | input | AW | Request address |
| req_wdata | input | DW | Store data |
| req_be | input | DW/8 | Store byte enables |
| core_idle | output | 1 | Unit accepts a request this cycle |
| core_done | output | 1 | Transfer finished (one cycle) |
| core_rdata | output | DW | Read data, valid with done |
| bus_addr | output | AW | Bus address |
| bus_wdata | output | DW | Bus write data |
| bus_rstrb | output | 1 | One-cycle read strobe |
| bus_wmask | output | DW/8 | One-cycle write byte mask |
| bus_rdata | input | DW | Bus read data |
| bus_rbusy | input | 1 | Read busy from slave |
| bus_wbusy | input | 1 | Write busy from slave |

## Verification
On every cycle, the assertions check the following:
- the strobe and mask are single-cycle pulses and are never active together;
- no pulse is issued while a transfer is outstanding;
- address and data hold steady until done;
- done follows a non-busy sample by one cycle, is withheld while busy is seen, and lasts one cycle.

Only the bench scenarios can show certain other properties. These are the exact request-to-done latency for a chosen busy length, the correctness of returned read data against a reference memory, and the fact that blocked requests and all-zero-enable stores are dropped. The slave model presents poison data while busy to expose early capture.

// File: rtl/sbus_master.sv
module sbus_master #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_load,
  input  logic            req_store,
  input  logic [AW-1:0]   req_addr,
  input  logic [DW-1:0]   req_wdata,
  input  logic [DW/8-1:0] req_be,
  output logic            core_idle,
  output logic            core_done,
  output logic [DW-1:0]   core_rdata,
  output logic [AW-1:0]   bus_addr,
  output logic [DW-1:0]   bus_wdata,
  output logic            bus_rstrb,
  output logic [DW/8-1:0] bus_wmask,
  input  logic [DW-1:0]   bus_rdata,
  input  logic            bus_rbusy,
  input  logic            bus_wbusy
);
  localparam int NB = DW / 8;

  typedef enum logic [1:0] {S_IDLE, S_PULSE, S_WAIT} state_t;

  state_t          state;
  logic            is_rd;
  logic [NB-1:0]   be_q;
  logic [AW-1:0]   addr_q;
  logic [DW-1:0]   wdata_q;
  logic [DW-1:0]   rdata_q;
  logic            done_q;

  logic take_rd, take_wr, busy_now;

  assign core_idle = (state == S_IDLE);
  assign take_rd   = core_idle && req_load;
  assign take_wr   = core_idle && !req_load && req_store && (|req_be);
  assign busy_now  = is_rd ? bus_rbusy : bus_wbusy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      is_rd   <= 1'b0;
      be_q    <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state)
        S_IDLE: if (take_rd || take_wr) begin
          state   <= S_PULSE;
          is_rd   <= take_rd;
          be_q    <= take_rd ? '0 : req_be;
          addr_q  <= req_addr;
          wdata_q <= req_wdata;
        end
        S_PULSE: state <= S_WAIT;
        S_WAIT: if (!busy_now) begin
          state  <= S_IDLE;
          done_q <= 1'b1;
          if (is_rd) rdata_q <= bus_rdata;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign bus_addr   = addr_q;
  assign bus_wdata  = wdata_q;
  assign bus_rstrb  = (state == S_PULSE) && is_rd;
  assign bus_wmask  = (state == S_PULSE && !is_rd) ? be_q : '0;
  assign core_done  = done_q;
  assign core_rdata = rdata_q;
endmodule

// File: rtl/sbus_master_chk.sv
module sbus_master_chk #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            core_done,
  input logic [AW-1:0]   bus_addr,
  input logic [DW-1:0]   bus_wdata,
  input logic            bus_rstrb,
  input logic [DW/8-1:0] bus_wmask,
  input logic            bus_rbusy,
  input logic            bus_wbusy
);
  logic pend_q, pulse_q, rd_q, busy_c, pulse;

  assign pulse  = bus_rstrb || (|bus_wmask);
  assign busy_c = rd_q ? bus_rbusy : bus_wbusy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      pulse_q <= 1'b0;
      rd_q    <= 1'b0;
    end else begin
      pulse_q <= pulse;
      if (pulse) begin
        pend_q <= 1'b1;
        rd_q   <= bus_rstrb;
      end else if (core_done) begin
        pend_q <= 1'b0;
      end
    end
  end

  p_rstrb_one_r1: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rstrb |=> !bus_rstrb);
  p_wmask_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|bus_wmask) |=> (bus_wmask == '0));
  p_fast_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_q && !busy_c) |=> core_done);
  p_busy_stall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !core_done && busy_c) |=> !core_done);
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> ($stable(bus_addr) && $stable(bus_wdata)));
  p_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rstrb && (|bus_wmask)));
  p_no_reissue_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> (!bus_rstrb && bus_wmask == '0));
  p_done_one_r10: assert property (@(posedge clk) disable iff (!rst_n)
    core_done |=> !core_done);
endmodule

bind sbus_master sbus_master_chk #(.AW(AW), .DW(DW)) u_chk (.*);

// File: tb/test_sbus_master.sv
module test_sbus_master;
  logic        clk = 0, rst_n = 0;
  logic        req_load = 0, req_store = 0;
  logic [31:0] req_addr = 0, req_wdata = 0;
  logic [3:0]  req_be = 0;
  logic        core_idle, core_done;
  logic [31:0] core_rdata, bus_addr, bus_wdata, bus_rdata;
  logic        bus_rstrb, bus_rbusy, bus_wbusy;
  logic [3:0]  bus_wmask;

  sbus_master i_sbus_master (.*);

  always #5 clk = ~clk;

  int nvec = 0, nerr = 0;
  logic [31:0] slv_mem [16];
  logic [31:0] ref_mem [16];
  int   rem = 0, last_len = 0, pulses = 0, max_len = 4;
  bit   tie_low = 0;
  logic [31:0] seen_addr, seen_wdata;
  logic [3:0]  seen_mask;
  bit   seen_rd;

  assign bus_rbusy = (rem != 0) && seen_rd;
  assign bus_wbusy = (rem != 0) && !seen_rd;
  assign bus_rdata = (rem != 0) ? 32'hBAD0_BAD0 : slv_mem[bus_addr[5:2]];

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    nvec++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (rst_n && (bus_rstrb || bus_wmask != 0)) begin
      int l;
      l = tie_low ? 0 : int'($urandom_range(max_len, 0));
      last_len   = l;
      rem       <= l;
      pulses++;
      seen_rd    = bus_rstrb;
      seen_addr  = bus_addr;
      seen_wdata = bus_wdata;
      seen_mask  = bus_wmask;
      for (int b = 0; b < 4; b++)
        if (bus_wmask[b]) slv_mem[bus_addr[5:2]][8*b +: 8] <= bus_wdata[8*b +: 8];
    end else if (rem != 0) begin
      chk(bus_addr == seen_addr && bus_wdata == seen_wdata, "R5 hold",
          bus_addr ^ bus_wdata, seen_addr ^ seen_wdata);
      rem <= rem - 1;
    end
  end

  function automatic logic [31:0] merge(logic [31:0] old, logic [31:0] nw, logic [3:0] be);
    logic [31:0] r = old;
    for (int b = 0; b < 4; b++) if (be[b]) r[8*b +: 8] = nw[8*b +: 8];
    return r;
  endfunction

  task automatic xfer(bit ld, bit st, logic [31:0] a, logic [31:0] wd, logic [3:0] be, bit poke);
    int n, p0;
    bit active;
    active = ld || (st && be != 0);
    @(negedge clk);
    chk(core_idle, "R10 idle before request", {31'b0, core_idle}, 1);
    p0 = pulses;
    req_load = ld; req_store = st; req_addr = a; req_wdata = wd; req_be = be;
    @(negedge clk);
    req_load = poke; req_store = poke; req_addr = ~a; req_wdata = ~wd; req_be = 4'hF;
    n = 1;
    if (!active) begin
      req_load = 0; req_store = 0;
      repeat (5) begin @(negedge clk); if (core_done) n = 99; end
      chk(n == 1 && pulses == p0, "R7 zero-enable store ignored", n, 1);
      return;
    end
    if (ld) chk(bus_rstrb && bus_addr == a, "R1 read strobe/address", bus_addr, a);
    else    chk(bus_wmask == be && bus_wdata == wd, "R2 write mask/data",
                {bus_wmask, bus_wdata[27:0]}, {be, wd[27:0]});
    @(negedge clk); n++;
    req_load = 0; req_store = 0;
    chk(!bus_rstrb && bus_wmask == 0, "R1/R2 single-cycle pulse", {bus_rstrb, bus_wmask}, 0);
    while (!core_done && n < 40) begin @(negedge clk); n++; end
    chk(n == 3 + last_len, ld ? "R3 read latency" : "R3 write latency", n, 3 + last_len);
    chk(pulses == p0 + 1, "R6 one pulse per transfer, busy requests ignored", pulses - p0, 1);
    chk(core_idle, "R10 idle with done", {31'b0, core_idle}, 1);
    if (ld) begin
      chk(seen_rd, "R8 load wins over store", {31'b0, seen_rd}, 1);
      chk(core_rdata == ref_mem[a[5:2]], "R4 read data", core_rdata, ref_mem[a[5:2]]);
    end else begin
      ref_mem[a[5:2]] = merge(ref_mem[a[5:2]], wd, be);
    end
    @(negedge clk);
    chk(!core_done, "R10 done single cycle", {31'b0, core_done}, 0);
  endtask

  initial begin
    int guard = 0;
    forever begin
      @(posedge clk);
      guard++;
      if (guard > 150000) begin
        nvec++; nerr++;
        $display("FAIL watchdog: actual %0d expected < 150000", guard);
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 16; i++) begin
      slv_mem[i] = 32'h1000_0001 * (i + 3);
      ref_mem[i] = slv_mem[i];
    end
    repeat (3) @(negedge clk);
    chk(core_idle && !core_done && !bus_rstrb && bus_wmask == 0, "R9 reset state",
        {core_idle, core_done, bus_rstrb, bus_wmask}, 7'b1000000);
    rst_n = 1;
    tie_low = 1;
    xfer(1, 0, 32'h14, 0, 0, 0);
    xfer(0, 1, 32'h14, 32'hA1B2C3D4, 4'b0101, 0);
    xfer(1, 0, 32'h14, 0, 0, 0);
    tie_low = 0;
    max_len = 0;
    xfer(1, 0, 32'h08, 0, 0, 1);
    max_len = 4;
    xfer(0, 1, 32'h08, 32'hFFFF_FFFF, 4'b0000, 0);
    xfer(1, 0, 32'h08, 0, 0, 0);
    xfer(1, 1, 32'h0C, 32'h5555_5555, 4'hF, 0);
    xfer(1, 0, 32'h0C, 0, 0, 0);
    for (int k = 0; k < 400; k++) begin
      bit ld, poke;
      ld   = $urandom_range(1, 0) == 1;
      poke = $urandom_range(3, 0) == 0;
      xfer(ld, !ld, {26'b0, 4'($urandom_range(15, 0)), 2'b00}, $urandom,
           4'($urandom_range(15, 0)), poke);
    end
    tie_low = 1;
    for (int k = 0; k < 16; k++) xfer(1, 0, 32'(k * 4), 0, 0, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule